// File: doc/BRIEF.md
# Serial EEPROM Boot Loader with Checksum

This block fetches the full contents of a small three-wire serial EEPROM into on-chip storage as soon as reset is released. The EEPROM holds 64 words of 16 bits. The loader drives the chip select, the serial clock and the serial data-in pin of the EEPROM, and it samples the serial data-out pin. Every word is read with its own command. The command is a start bit followed by a two-bit read opcode and the six-bit word address. The serial clock is generated by a state sequencer. Every state of that sequencer lasts a programmable number of core clock cycles, which sets the minimum hold time of each pin change (one microsecond at the default setting).

As each word arrives, the loader writes it into a 64-entry array and adds it into a 16-bit sum that wraps on overflow. When the last word has been read, the loader raises a sticky done flag. A checksum-good flag shows whether the sum equals the fixed signature 0xBABA. The rest of the chip reads the loaded words through an asynchronous read port. A start pulse given while the loader is not busy runs the whole load again.

Top module: `mw_rom_loader`

## Requirements
- R1: After reset is released, a load begins on its own. Each load reads addresses 0 to 63 in ascending order, with exactly one read command per word.
- R2: Each command raises chip select, then clocks out 9 bits most significant bit first: a start bit of 1, the opcode bits 1 then 0, then the 6-bit address. The EEPROM samples each bit on the rising edge of the serial clock.
- R3: Each command bit is sent in three steps: data-in is set, then the serial clock goes high, then the serial clock goes low. The serial clock is high only while chip select is high. Data-in and chip select do not change on the cycle the serial clock rises.
- R4: After any change on chip select, serial clock or data-in, none of these pins changes again for at least STEP_CYCLES clock cycles.
- R5: After the 16th data bit of a word, chip select, data-in and serial clock are all low together for one step before the next command begins. All three stay low while done is high.
- R6: Each of the 16 data bits is sampled from data-out at the end of a serial-clock-high step, most significant bit first. The word is stored at its own address, and rd_data_o shows the word at rd_addr_i combinationally.
- R7: done_o rises exactly 61*64*STEP_CYCLES cycles after the clock edge that starts a load, and it then stays high until a new load starts.
- R8: sum_ok_o is 1 only while done_o is 1 and the 16-bit sum of all 64 words, wrapping on overflow, equals 0xBABA. It is 0 during a load.
- R9: A start_i pulse during a load is ignored: the address order and the timing of done are unchanged. A start_i pulse while the loader is idle clears done_o on the next edge and begins a new load from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new load while idle |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data to the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |
| rd_addr_i | input | ADDR_W | Word address of the read port |
| rd_data_o | output | DATA_W | Loaded word at rd_addr_i |
| done_o | output | 1 | Load finished (sticky) |
| sum_ok_o | output | 1 | Sum of the words equals the signature |

## Verification
A start request can arrive in the same cycle as any step of the serial sequencer, including a data-bit sample or the word write that feeds the checksum adder. The bench provokes this by pulsing start_i in the middle of a load. It then judges the result in three ways: the EEPROM model still sees every address in unbroken ascending order, done_o rises in the exact cycle computed from the first start, and the stored words still match. A start pulse also meets a high done flag in the same cycle. That case is judged by done_o dropping one edge later and the sum being rebuilt from zero, so that an image with a bad checksum is flagged and a good one that follows it is accepted.

// File: rtl/mwl_pkg.sv
package mwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD_DI,
    ST_CMD_HI,
    ST_CMD_LO,
    ST_RD_HI,
    ST_RD_LO,
    ST_DESEL
  } mwl_state_e;

  localparam logic [1:0] RD_OPCODE = 2'b10;
endpackage

// File: rtl/mwl_step_timer.sv
module mwl_step_timer #(
  parameter int STEP_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mwl_seq.sv
module mwl_seq
  import mwl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              do_i,
  output logic              run_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              clr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o
);
  localparam int CMD_W = ADDR_W + 3;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BIT_W = $clog2(MAXB);

  mwl_state_e        state_q;
  logic              kick_q;
  logic              di_q;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BIT_W-1:0]  bit_dec;
  logic [DATA_W-1:0] sh_q;
  logic [CMD_W-1:0]  cmd;
  logic              launch;

  assign cmd     = {1'b1, RD_OPCODE, addr_q};
  assign bit_dec = bit_q - 1'b1;
  assign launch  = (state_q == ST_IDLE) && (kick_q || start_i);

  assign run_o     = (state_q != ST_IDLE);
  assign cs_o      = (state_q != ST_IDLE) && (state_q != ST_DESEL);
  assign sk_o      = (state_q == ST_CMD_HI) || (state_q == ST_RD_HI);
  assign di_o      = di_q;
  assign done_o    = done_q;
  assign clr_o     = launch;
  assign wr_o      = (state_q == ST_RD_HI) && tick_i && (bit_q == '0);
  assign wr_addr_o = addr_q;
  assign wr_data_o = {sh_q[DATA_W-2:0], do_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kick_q  <= 1'b1;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (launch) begin
            kick_q  <= 1'b0;
            done_q  <= 1'b0;
            addr_q  <= '0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (tick_i) begin
            di_q    <= cmd[CMD_W-1];
            bit_q   <= BIT_W'(CMD_W - 1);
            state_q <= ST_CMD_DI;
          end
        end
        ST_CMD_DI: if (tick_i) state_q <= ST_CMD_HI;
        ST_CMD_HI: if (tick_i) state_q <= ST_CMD_LO;
        ST_CMD_LO: begin
          if (tick_i) begin
            if (bit_q != '0) begin
              bit_q   <= bit_dec;
              di_q    <= cmd[bit_dec];
              state_q <= ST_CMD_DI;
            end else begin
              bit_q   <= BIT_W'(DATA_W - 1);
              state_q <= ST_RD_HI;
            end
          end
        end
        ST_RD_HI: begin
          if (tick_i) begin
            sh_q    <= {sh_q[DATA_W-2:0], do_i};
            state_q <= ST_RD_LO;
          end
        end
        ST_RD_LO: begin
          if (tick_i) begin
            if (bit_q != '0) begin
              bit_q   <= bit_dec;
              state_q <= ST_RD_HI;
            end else begin
              di_q    <= 1'b0;
              state_q <= ST_DESEL;
            end
          end
        end
        ST_DESEL: begin
          if (tick_i) begin
            if (&addr_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_SEL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwl_store.sv
module mwl_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] sum_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] sum_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (wr_i)  sum_q <= sum_q + wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign sum_o     = sum_q;
endmodule

// File: rtl/mw_rom_loader.sv
module mw_rom_loader #(
  parameter int              STEP_CYCLES = 50,
  parameter int              ADDR_W      = 6,
  parameter int              DATA_W      = 16,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              sum_ok_o
);
  logic              run, tick, clr, wr, done;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, sum;

  mwl_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  mwl_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .tick_i   (tick),
    .do_i     (do_i),
    .run_o    (run),
    .cs_o     (cs_o),
    .sk_o     (sk_o),
    .di_o     (di_o),
    .clr_o    (clr),
    .wr_o     (wr),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .done_o   (done)
  );

  mwl_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .wr_i     (wr),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .sum_o    (sum)
  );

  assign done_o   = done;
  assign sum_ok_o = done && (sum == SIGNATURE);
endmodule

// File: rtl/mwl_checker.sv
module mwl_checker #(
  parameter int STEP_CYCLES = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_o,
  input logic sk_o,
  input logic di_o,
  input logic done_o
);
  logic [2:0]  pins, pins_q;
  logic [31:0] held_q;

  assign pins = {cs_o, sk_o, di_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= '0;
      held_q <= 32'(STEP_CYCLES);
    end else begin
      pins_q <= pins;
      if (pins != pins_q)                   held_q <= 32'd1;
      else if (held_q < 32'(STEP_CYCLES))   held_q <= held_q + 32'd1;
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o); // R3
  AST_SK_RISE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sk_o) |-> ($stable(di_o) && $stable(cs_o))); // R3
  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins != pins_q) |-> (held_q >= 32'(STEP_CYCLES))); // R4
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cs_o && !sk_o && !di_o)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R7
  AST_DONE_AFTER_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(cs_o)); // R7
endmodule

bind mw_rom_loader mwl_checker #(.STEP_CYCLES(STEP_CYCLES)) u_mwl_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .cs_o   (cs_o),
  .sk_o   (sk_o),
  .di_o   (di_o),
  .done_o (done_o)
);

// File: tb/tb_mw_rom_loader.sv
`timescale 1ns/1ps
module tb_mw_rom_loader;
  localparam int STEP = 3;
  localparam int LOAD = 61 * 64 * STEP;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic        cs, sk, di;
  logic        do_r = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        done, sum_ok;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [15:0] img [64];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mw_rom_loader #(.STEP_CYCLES(STEP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(do_r),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .done_o(done), .sum_ok_o(sum_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // image kinds computed arithmetically; last word fixes (or breaks) the sum
  task automatic build_image(input int kind, input bit good);
    logic [15:0] s = '0;
    for (int a = 0; a < 63; a++) begin
      case (kind)
        0:       img[a] = 16'(a * 16'h0101) ^ 16'h5A5A;
        1:       img[a] = 16'hFFFF - 16'(a);
        default: img[a] = 16'(a * a * 37 + 11);
      endcase
      s = s + img[a];
    end
    img[63] = 16'hBABA - s + (good ? 16'd0 : 16'd1);
  endtask

  // EEPROM model
  int         ph = 0, nb = 0, rb = 0, exp_addr = 0;
  logic [7:0] cb;
  logic [5:0] ma;
  always @(posedge sk or negedge cs) begin
    if (!cs) begin
      ph = 0;
      do_r = 1'b0;
    end else if (ph == 0) begin
      chk(di == 1'b1, "R2 start bit", int'(di), 1);
      ph = 1; nb = 0; cb = '0;
    end else if (ph == 1) begin
      cb = {cb[6:0], di};
      nb++;
      if (nb == 8) begin
        chk(cb[7:6] == 2'b10, "R2 opcode", int'(cb[7:6]), 2);
        chk(cb[5:0] == 6'(exp_addr), "R1 address order", int'(cb[5:0]), exp_addr);
        ma = cb[5:0];
        exp_addr = (exp_addr + 1) % 64;
        ph = 2; rb = 15;
      end
    end else begin
      do_r = (rb >= 0) ? img[ma][rb] : 1'b0;
      rb--;
    end
  end

  // pin timing monitor
  logic [2:0] pp = '0;
  int hold = 1000;
  always @(negedge clk) begin
    if (rst_ni) begin
      if ({cs, sk, di} != pp) begin
        chk(hold >= STEP, "R4 pin hold", hold, STEP);
        if (!pp[1] && sk) chk(cs && (di == pp[0]) && pp[2], "R3 clock rise", {29'd0, cs, sk, di}, 6);
        if (pp[2] && !cs) chk(!sk && !di, "R5 deselect", {29'd0, cs, sk, di}, 0);
        hold = 1;
      end else begin
        hold++;
      end
      pp = {cs, sk, di};
    end
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic check_words(input bit exp_ok);
    for (int a = 0; a < 64; a++) begin
      rd_addr = 6'(a);
      #1;
      chk(rd_data == img[a], "R6 stored word", int'(rd_data), int'(img[a]));
    end
    chk(sum_ok == exp_ok, "R8 checksum flag", int'(sum_ok), int'(exp_ok));
  endtask

  // pulse start at a negedge; returns cycle count after the capturing edge
  task automatic pulse_start(output int c0);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    c0 = cyc;
    chk(done == 1'b0, "R9 done cleared on start", int'(done), 0);
  endtask

  initial begin
    int c0;
    build_image(0, 1'b1);
    repeat (3) @(negedge clk);
    chk({cs, sk, di, done, sum_ok} == 5'b0, "R5 reset outputs", int'({cs, sk, di, done, sum_ok}), 0);
    rst_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    c0 = cyc;
    chk(cs == 1'b1, "R1 auto load after reset", int'(cs), 1);
    wait_cyc(c0 + LAST_OFF());
    chk(done == 1'b0, "R7 done not early", int'(done), 0);
    chk(sum_ok == 1'b0, "R8 flag low while loading", int'(sum_ok), 0);
    wait_cyc(c0 + LOAD);
    chk(done == 1'b1, "R7 done on time", int'(done), 1);
    check_words(1'b1);

    // bad checksum image, start pulse mid-load must be ignored
    build_image(1, 1'b0);
    pulse_start(c0);
    wait_cyc(c0 + 1000);
    chk(cs == 1'b1, "R9 busy before stray start", int'(cs), 1);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(sum_ok == 1'b0, "R8 flag low while loading", int'(sum_ok), 0);
    wait_cyc(c0 + LAST_OFF());
    chk(done == 1'b0, "R9 done not early after stray start", int'(done), 0);
    wait_cyc(c0 + LOAD);
    chk(done == 1'b1, "R9 done timing unchanged", int'(done), 1);
    check_words(1'b0);

    // good image after a bad one: sum rebuilt from zero
    build_image(2, 1'b1);
    pulse_start(c0);
    wait_cyc(c0 + LAST_OFF());
    chk(done == 1'b0, "R7 done not early", int'(done), 0);
    wait_cyc(c0 + LOAD);
    chk(done == 1'b1, "R7 done on time", int'(done), 1);
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R7 done sticky", int'(done), 1);
    check_words(1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  function automatic int LAST_OFF();
    return LOAD - 1;
  endfunction

  initial begin
    #(20ns * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 3 * LOAD);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule